// File: doc/BRIEF.md
# Partial Register Rename Merge Tracker

This block sits in the rename stage of a core whose architectural registers are 32 bits wide. Each register can be named as a whole, as its bottom byte, or as its second byte (the high byte). The tracker accepts one decoded micro-op per cycle. For that micro-op it is told which register is read and which is written, and through which lane. It renames the micro-op to physical tags and states which earlier tags each source depends on.

The high byte is renamed apart from the rest of the register. Once it has been written, the register is marked dirty. A bottom-byte write is never renamed apart. It is a blend into the whole register: it allocates a new full tag and depends on the previous one. When a whole-register read finds the register dirty, the tracker raises `stall` and injects one merge micro-op. The merge joins the full tag and the high-byte tag into a fresh full tag and clears the dirty mark. The decoder holds the same consumer for one more cycle, and the consumer is then renamed against the merged tag. A high-byte read of a register that is clean carries one extra cycle of source latency.

Top module: `partial_rename_tracker`

## Requirements
- R1: After reset every register is clean and register i maps to physical tag i for both its full view and its high byte. The next tag to allocate is NUM_ARCH, and all outputs are low.
- R2: A high-byte write (dst kind 2) with `in_dst_move`=1 allocates a new tag for the high byte and marks the register dirty. It reports no second source.
- R3: A high-byte write with `in_dst_move`=0 also allocates a high-byte tag and sets dirty. Its second source is the old high-byte value: the high-byte tag if the register was dirty, otherwise the full tag.
- R4: A bottom-byte write (dst kind 1) allocates a new full tag with the old full tag as its second source. It leaves the dirty mark unchanged and never causes a merge.
- R5: A whole-register read (src kind 3) of a dirty register raises `stall` in the same cycle. The next cycle shows a merge micro-op whose destination is a new full tag, with source A the old full tag and source B the high-byte tag. The register is then clean, and the held consumer is renamed the cycle after with source A equal to the merged tag.
- R6: A whole-register write (dst kind 3) allocates a new full tag, reports no second source and clears the dirty mark.
- R7: A high-byte read (src kind 2) returns the high-byte tag with latency 0 when the register is dirty. When the register is clean it returns the full tag with `out_src_lat`=1.
- R8: A bottom-byte read (src kind 1) returns the full tag with latency 0 and never stalls, even when the register is dirty.
- R9: Every emitted micro-op with a destination, merges included, takes the next tag in increasing order, wrapping modulo 2^TAG_W. A micro-op with dst kind 0 allocates nothing.
- R10: With `in_valid` low, nothing is emitted on the following cycle and no mapping or dirty mark changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A micro-op is presented |
| in_src_reg | input | RW | Source architectural register |
| in_src_kind | input | 2 | Source lane: 0 none, 1 bottom byte, 2 high byte, 3 whole |
| in_dst_reg | input | RW | Destination architectural register |
| in_dst_kind | input | 2 | Destination lane, same encoding |
| in_dst_move | input | 1 | High-byte write is a plain byte move (no old-value dependency) |
| stall | output | 1 | Merge injected this cycle; hold the micro-op |
| out_valid | output | 1 | Renamed micro-op emitted |
| out_merge | output | 1 | The emitted micro-op is a merge |
| out_dst_vld | output | 1 | Destination tag is valid |
| out_dst_tag | output | TAG_W | Allocated destination tag |
| out_src_a_vld | output | 1 | Source A valid |
| out_src_a | output | TAG_W | Source A tag |
| out_src_b_vld | output | 1 | Source B valid |
| out_src_b | output | TAG_W | Source B tag (old value or merge high byte) |
| out_src_lat | output | 1 | One extra cycle of latency on source A |

## Verification
`stall` is combinational and is due in the cycle the micro-op is presented. Every renamed result sits behind one register and is due one clock after the accepting edge. The bench drives inputs on the falling edge and samples `stall` shortly after. It then waits through exactly one rising edge and reads the renamed outputs on the next falling edge. A stalled micro-op is held unchanged for the merge cycle and checked again on the cycle after. The model of mappings, dirty marks and the tag counter is updated only when the bench observes an accepting edge.

// File: rtl/partial_rename_tracker.sv
module partial_rename_tracker #(
  parameter int NUM_ARCH = 4,
  parameter int TAG_W    = 6,
  localparam int RW      = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [RW-1:0]    in_src_reg,
  input  logic [1:0]       in_src_kind,
  input  logic [RW-1:0]    in_dst_reg,
  input  logic [1:0]       in_dst_kind,
  input  logic             in_dst_move,
  output logic             stall,
  output logic             out_valid,
  output logic             out_merge,
  output logic             out_dst_vld,
  output logic [TAG_W-1:0] out_dst_tag,
  output logic             out_src_a_vld,
  output logic [TAG_W-1:0] out_src_a,
  output logic             out_src_b_vld,
  output logic [TAG_W-1:0] out_src_b,
  output logic             out_src_lat
);
  localparam logic [1:0] K_NONE = 2'd0, K_LO = 2'd1, K_HI = 2'd2, K_FULL = 2'd3;

  logic [TAG_W-1:0] full_tag [NUM_ARCH];
  logic [TAG_W-1:0] hi_tag   [NUM_ARCH];
  logic [NUM_ARCH-1:0] dirty;
  logic [TAG_W-1:0] next_tag;

  wire src_dirty  = dirty[in_src_reg];
  wire need_merge = in_valid && (in_src_kind == K_FULL) && src_dirty;
  wire [TAG_W-1:0] dst_hi_old = dirty[in_dst_reg] ? hi_tag[in_dst_reg] : full_tag[in_dst_reg];

  assign stall = need_merge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        full_tag[i] <= TAG_W'(i);
        hi_tag[i]   <= TAG_W'(i);
      end
      dirty         <= '0;
      next_tag      <= TAG_W'(NUM_ARCH);
      out_valid     <= 1'b0;
      out_merge     <= 1'b0;
      out_dst_vld   <= 1'b0;
      out_dst_tag   <= '0;
      out_src_a_vld <= 1'b0;
      out_src_a     <= '0;
      out_src_b_vld <= 1'b0;
      out_src_b     <= '0;
      out_src_lat   <= 1'b0;
    end else begin
      out_valid     <= 1'b0;
      out_merge     <= 1'b0;
      out_dst_vld   <= 1'b0;
      out_dst_tag   <= '0;
      out_src_a_vld <= 1'b0;
      out_src_a     <= '0;
      out_src_b_vld <= 1'b0;
      out_src_b     <= '0;
      out_src_lat   <= 1'b0;
      if (need_merge) begin
        out_valid             <= 1'b1;
        out_merge             <= 1'b1;
        out_dst_vld           <= 1'b1;
        out_dst_tag           <= next_tag;
        out_src_a_vld         <= 1'b1;
        out_src_a             <= full_tag[in_src_reg];
        out_src_b_vld         <= 1'b1;
        out_src_b             <= hi_tag[in_src_reg];
        full_tag[in_src_reg]  <= next_tag;
        dirty[in_src_reg]     <= 1'b0;
        next_tag              <= next_tag + TAG_W'(1);
      end else if (in_valid) begin
        out_valid <= 1'b1;
        case (in_src_kind)
          K_LO, K_FULL: begin
            out_src_a_vld <= 1'b1;
            out_src_a     <= full_tag[in_src_reg];
          end
          K_HI: begin
            out_src_a_vld <= 1'b1;
            out_src_a     <= src_dirty ? hi_tag[in_src_reg] : full_tag[in_src_reg];
            out_src_lat   <= !src_dirty;
          end
          default: ;
        endcase
        if (in_dst_kind != K_NONE) begin
          out_dst_vld <= 1'b1;
          out_dst_tag <= next_tag;
          next_tag    <= next_tag + TAG_W'(1);
        end
        case (in_dst_kind)
          K_LO: begin
            out_src_b_vld         <= 1'b1;
            out_src_b             <= full_tag[in_dst_reg];
            full_tag[in_dst_reg]  <= next_tag;
          end
          K_HI: begin
            hi_tag[in_dst_reg] <= next_tag;
            dirty[in_dst_reg]  <= 1'b1;
            if (!in_dst_move) begin
              out_src_b_vld <= 1'b1;
              out_src_b     <= dst_hi_old;
            end
          end
          K_FULL: begin
            full_tag[in_dst_reg] <= next_tag;
            dirty[in_dst_reg]    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assert_merge_follows_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (out_valid && out_merge && out_dst_vld));

  assert_merge_cleans_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !dirty[$past(in_src_reg)]);

  assert_merge_two_sources_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_merge |-> (out_src_a_vld && out_src_b_vld && !out_src_lat));

  assert_lat_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_src_lat |-> (out_valid && out_src_a_vld && !out_merge));

  assert_idle_emits_nothing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_tag_advances_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dst_vld && $past(rst_n)) |-> (out_dst_tag == $past(next_tag)));
endmodule

// File: tb/partial_rename_tracker_test.sv
module partial_rename_tracker_test;
  localparam int NA = 4;
  localparam int TW = 6;
  localparam int RW = 2;
  localparam int VW = 6 + 3 * TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [RW-1:0] in_src_reg = '0, in_dst_reg = '0;
  logic [1:0] in_src_kind = '0, in_dst_kind = '0;
  logic in_dst_move = 1'b0;
  logic stall, out_valid, out_merge, out_dst_vld, out_src_a_vld, out_src_b_vld, out_src_lat;
  logic [TW-1:0] out_dst_tag, out_src_a, out_src_b;

  partial_rename_tracker #(.NUM_ARCH(NA), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_src_reg(in_src_reg), .in_src_kind(in_src_kind),
    .in_dst_reg(in_dst_reg), .in_dst_kind(in_dst_kind), .in_dst_move(in_dst_move),
    .stall(stall), .out_valid(out_valid), .out_merge(out_merge),
    .out_dst_vld(out_dst_vld), .out_dst_tag(out_dst_tag),
    .out_src_a_vld(out_src_a_vld), .out_src_a(out_src_a),
    .out_src_b_vld(out_src_b_vld), .out_src_b(out_src_b), .out_src_lat(out_src_lat));

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  logic [TW-1:0] m_full [NA];
  logic [TW-1:0] m_hi [NA];
  logic m_dirty [NA];
  logic [TW-1:0] m_next;

  function automatic logic [VW-1:0] pack(input logic v, m, dv, input logic [TW-1:0] d,
                                         input logic av, input logic [TW-1:0] a,
                                         input logic bv, input logic [TW-1:0] b, input logic l);
    return {v, m, dv, d, av, a, bv, b, l};
  endfunction

  task automatic check(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [VW-1:0] outs();
    return pack(out_valid, out_merge, out_dst_vld, out_dst_tag, out_src_a_vld, out_src_a,
                out_src_b_vld, out_src_b, out_src_lat);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NA; i++) begin
      m_full[i] = TW'(i); m_hi[i] = TW'(i); m_dirty[i] = 1'b0;
    end
    m_next = TW'(NA);
  endtask

  // Present one micro-op at a falling edge, handle a possible merge, check all results.
  task automatic issue(input int s, input int sk, input int d, input int dk, input logic mv);
    logic [VW-1:0] e;
    logic [TW-1:0] a, b, dt;
    logic av, bv, lat, dv;
    string req;
    in_valid = 1'b1;
    in_src_reg = RW'(s); in_src_kind = 2'(sk);
    in_dst_reg = RW'(d); in_dst_kind = 2'(dk); in_dst_move = mv;
    #1;
    if (sk == 3 && m_dirty[s]) begin
      check("R5 stall", {{(VW-1){1'b0}}, stall}, {{(VW-1){1'b0}}, 1'b1});
      e = pack(1, 1, 1, m_next, 1, m_full[s], 1, m_hi[s], 0);
      m_full[s] = m_next; m_dirty[s] = 1'b0; m_next = m_next + TW'(1);
      @(posedge clk); @(negedge clk);
      check("R5 merge", outs(), e);
      #1;
    end
    check("R8 R4 no stall", {{(VW-1){1'b0}}, stall}, '0);
    av = (sk != 0); lat = 0; a = '0;
    if (sk == 1 || sk == 3) a = m_full[s];
    if (sk == 2) begin a = m_dirty[s] ? m_hi[s] : m_full[s]; lat = !m_dirty[s]; end
    dv = (dk != 0); dt = dv ? m_next : '0; bv = 0; b = '0;
    if (dk == 1) begin bv = 1; b = m_full[d]; m_full[d] = m_next; end
    if (dk == 2) begin
      if (!mv) begin bv = 1; b = m_dirty[d] ? m_hi[d] : m_full[d]; end
      m_hi[d] = m_next; m_dirty[d] = 1'b1;
    end
    if (dk == 3) begin m_full[d] = m_next; m_dirty[d] = 1'b0; end
    if (dv) m_next = m_next + TW'(1);
    e = pack(1, 0, dv, dt, av, a, bv, b, lat);
    if (sk == 3) req = "R5 consumer";
    else if (dk == 2) req = mv ? "R2" : "R3";
    else if (dk == 1) req = "R4";
    else if (dk == 3) req = "R6";
    else if (sk == 2) req = "R7";
    else if (sk == 1) req = "R8";
    else req = "R9";
    @(posedge clk); @(negedge clk);
    check(req, outs(), e);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check("R10 idle", outs(), '0);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset", outs(), '0);
    rst_n = 1'b1;
    // R1: each register maps to its own tag: whole read of each register
    for (int r = 0; r < NA; r++) issue(r, 3, 0, 0, 0);
    // R7 clean high read latency, R2 then dirty high read
    issue(1, 2, 0, 0, 0);
    issue(0, 0, 1, 2, 1);
    issue(1, 2, 0, 0, 0);
    // R8 low read of dirty register: no stall
    issue(1, 1, 2, 0, 0);
    // R4 low write on dirty register keeps dirty
    issue(0, 0, 1, 1, 0);
    // R3 non-move high write on dirty register depends on high tag
    issue(0, 0, 1, 2, 0);
    // R5 whole read of dirty register
    issue(1, 3, 2, 3, 0);
    idle(3);
    // R6 full write clears dirty
    issue(0, 0, 2, 2, 1);
    issue(0, 0, 2, 3, 0);
    issue(2, 3, 3, 0, 0);
    // near-exhaustive sweep, wrapping the tag counter (R9)
    for (int s = 0; s < NA; s++)
      for (int sk = 0; sk < 4; sk++)
        for (int d = 0; d < NA; d++)
          for (int dk = 0; dk < 4; dk++)
            for (int mv = 0; mv < 2; mv++) begin
              issue(s, sk, d, dk, mv[0]);
              if (((s + d + dk) % 7) == 0) idle(1);
            end
    // R10: mapping unchanged across idle cycles
    idle(4);
    for (int r = 0; r < NA; r++) issue(r, 2, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule